// File: doc/BRIEF.md
# Keyboard Serial Link Transmitter

This block sends one byte from a keyboard controller to an attached keyboard over the two-wire, open-drain clock and data link. The host side loads a byte with a single-cycle strobe. The block then claims the link. It holds the clock line low for a configurable interval. It then drives the data line low as the start bit and releases the clock. From that point the keyboard generates the clock pulses.

On each falling edge of the keyboard clock the block presents the next frame bit. The order is the eight data bits from least significant upward, then a parity bit chosen so that data plus parity hold an odd number of ones, then a stop bit, which leaves the data line released. The keyboard confirms the byte by holding data low across one further falling clock edge. The block raises a one-cycle done pulse and goes idle.

A busy flag covers the whole exchange, and no new byte is taken while it is set. A watchdog counter bounds the exchange. If the acknowledge has not come within the limit, the block releases both lines and sets a sticky timeout flag. The two line-enable outputs connect to output port bits 6 (clock) and 7 (data) of the surrounding controller. The line readbacks come from its test inputs.

Top module: `kbd_tx_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_busy`, `tx_done`, `tx_timeout`, `kclk_pull` and `kdat_pull` are all 0. A pull output of 1 means the line is driven low, and 0 means the line is released.
- R2: A `tx_start` pulse seen while idle sets `tx_busy` and `kclk_pull` on the next clock edge. `kclk_pull` then stays 1 for exactly HOLD_CYCLES+1 cycles. `kdat_pull` is 1 only in the last of those cycles, and it is still 1 in the first cycle after `kclk_pull` falls (start bit).
- R3: After the clock is released, the keyboard clock falls numbered 1 to 10 put data bits D0..D7, then parity, then stop onto the data line. The line level equals the bit value, since `kdat_pull` = NOT bit. Each new value appears exactly SYNC_STAGES+1 cycles after the line fall and holds until the next fall.
- R4: The parity bit is chosen so that D0..D7 plus parity contain an odd number of ones. The stop bit is 1 (line released).
- R5: After the stop bit, a keyboard clock fall with data held low raises `tx_done` for one cycle and clears `tx_busy`. Both happen SYNC_STAGES+1 cycles after the fall, and `tx_busy` is still 1 one cycle earlier.
- R6: A `tx_start` pulse while `tx_busy` is 1 is ignored. The frame in flight is unchanged, and no second frame follows its acknowledge.
- R7: If no acknowledge arrives, `tx_busy` stays 1 for exactly TIMEOUT_CYCLES cycles after the accepting edge and then clears. At that point `tx_timeout` becomes 1, both pulls are 0, and no `tx_done` pulse occurs. A clock fall in the acknowledge phase with data high is not an acknowledge.
- R8: `tx_timeout` stays 1 until the next accepted `tx_start`. It reads 0 in the cycle after that accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | One-cycle strobe to send `tx_byte` |
| tx_byte | input | DATA_W | Byte to send, sampled with an accepted strobe |
| kclk_in | input | 1 | Keyboard clock line readback (test input) |
| kdat_in | input | 1 | Keyboard data line readback (test input) |
| kclk_pull | output | 1 | 1 drives the keyboard clock line low (output port bit 6) |
| kdat_pull | output | 1 | 1 drives the keyboard data line low (output port bit 7) |
| tx_busy | output | 1 | Transfer in progress |
| tx_done | output | 1 | One-cycle pulse on a received acknowledge |
| tx_timeout | output | 1 | Sticky transmit-timeout flag |

## Verification
Every keyboard-side result reaches the outputs SYNC_STAGES+1 cycles after the bench changes the line, because that many registers sit on the path. The bench checks one cycle earlier that the old value is still present, and then checks that the new value appears on the due cycle and stays until the next fall. The host-side results are counted in whole cycles from the accepting edge: busy and the clock pull appear one cycle after the strobe, the clock pull lasts HOLD_CYCLES+1 cycles, and an unanswered transfer holds busy for exactly TIMEOUT_CYCLES cycles. All of these are sampled on the falling edge of the controller clock. The bench sweeps every byte value through a modelled keyboard that clocks the frame and answers it. It also runs directed cases for a strobe during a transfer, a silent keyboard and a missing acknowledge.

// File: rtl/kbtx_pkg.sv
package kbtx_pkg;

  // Transfer sequencing states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // link released, waiting for a strobe
    ST_HOLD  = 3'd1,  // clock held low to claim the link
    ST_START = 3'd2,  // data low (start bit), clock still held
    ST_SHIFT = 3'd3,  // keyboard clocks out data, parity, stop
    ST_ACK   = 3'd4   // waiting for keyboard to pull data low
  } kbtx_state_e;

endpackage

// File: rtl/kbtx_sync.sv
// Multi-stage synchronizer for one asynchronous line; idles high.
module kbtx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= (pipe << 1) | STAGES'(din);
  end

  assign lvl = pipe[STAGES-1];

endmodule

// File: rtl/kbtx_timer.sv
// Up-counter that flags the last cycle of a LIMIT-cycle window.
module kbtx_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)          cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R7

endmodule

// File: rtl/kbtx_frame.sv
// Frame shifter: holds stop, parity and data; head bit is next to send.
module kbtx_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              shift,
  output logic              head
);

  localparam int FW = DATA_W + 2;

  logic [FW-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)        shreg <= '1;
    else if (load)  shreg <= {1'b1, ~(^data), data};
    else if (shift) shreg <= {1'b1, shreg[FW-1:1]};
  end

  assign head = shreg[0];

  AST_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
    load |=> (^shreg[DATA_W:0]) == 1'b1); // R4

  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    load |=> shreg[FW-1]); // R4

endmodule

// File: rtl/kbd_tx_engine.sv
module kbd_tx_engine
  import kbtx_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int HOLD_CYCLES    = 1200,
  parameter int TIMEOUT_CYCLES = 24000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              kclk_in,
  input  logic              kdat_in,
  output logic              kclk_pull,
  output logic              kdat_pull,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              tx_timeout
);

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int BW         = $clog2(FRAME_BITS + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam int NLINES     = 2;

  kbtx_state_e   state;
  logic          busy_q, done_q, tmo_q, clk_pull_q, dat_pull_q;
  logic [BW-1:0] bitcnt;
  logic          clk_prev;

  logic [NLINES-1:0] line_raw, line_lvl;
  logic clk_lvl, dat_lvl, clk_fall;
  logic accept, hold_exp, tmo_exp, head_bit, ack_evt, shift_evt;

  // Line synchronizers: index 0 clock, index 1 data
  assign line_raw = {kdat_in, kclk_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    kbtx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (line_raw[g]),
      .lvl (line_lvl[g])
    );
  end

  assign clk_lvl  = line_lvl[0];
  assign dat_lvl  = line_lvl[1];
  assign clk_fall = clk_prev && !clk_lvl;

  assign accept    = (state == ST_IDLE) && tx_start;
  assign shift_evt = (state == ST_SHIFT) && clk_fall;
  assign ack_evt   = (state == ST_ACK) && clk_fall && !dat_lvl;

  kbtx_timer #(.LIMIT(HOLD_CYCLES)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .run     (state == ST_HOLD),
    .expired (hold_exp)
  );

  kbtx_timer #(.LIMIT(TIMEOUT_CYCLES)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .run     (busy_q),
    .expired (tmo_exp)
  );

  kbtx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .data  (tx_byte),
    .shift (shift_evt),
    .head  (head_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      tmo_q      <= 1'b0;
      clk_pull_q <= 1'b0;
      dat_pull_q <= 1'b0;
      bitcnt     <= '0;
      clk_prev   <= 1'b1;
    end else begin
      clk_prev <= clk_lvl;
      done_q   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (tx_start) begin
            state      <= ST_HOLD;
            busy_q     <= 1'b1;
            tmo_q      <= 1'b0;
            clk_pull_q <= 1'b1;
            dat_pull_q <= 1'b0;
            bitcnt     <= '0;
          end
        end
        ST_HOLD: begin
          if (hold_exp) begin
            state      <= ST_START;
            dat_pull_q <= 1'b1;
          end
        end
        ST_START: begin
          clk_pull_q <= 1'b0;
          state      <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (clk_fall) begin
            dat_pull_q <= ~head_bit;
            bitcnt     <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) state <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (clk_fall && !dat_lvl) begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (tmo_exp && !ack_evt) begin
        state      <= ST_IDLE;
        busy_q     <= 1'b0;
        tmo_q      <= 1'b1;
        clk_pull_q <= 1'b0;
        dat_pull_q <= 1'b0;
      end
    end
  end

  assign kclk_pull  = clk_pull_q;
  assign kdat_pull  = dat_pull_q;
  assign tx_busy    = busy_q;
  assign tx_done    = done_q;
  assign tx_timeout = tmo_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!clk_pull_q && !dat_pull_q)); // R1

  AST_ACCEPT_CLAIMS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && tx_start) |=> (busy_q && clk_pull_q && !dat_pull_q)); // R2

  AST_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && !clk_fall && !tmo_exp) |=> $stable(dat_pull_q)); // R3

  AST_DONE_FROM_ACK: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(state == ST_ACK) && !$past(dat_lvl) && !busy_q)); // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && tx_start && !clk_fall && !tmo_exp)
      |=> (state == ST_SHIFT && $stable(bitcnt))); // R6

  AST_TMO_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(done_q && $rose(tmo_q))); // R7

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tmo_q && !(state == ST_IDLE && tx_start)) |=> tmo_q); // R8

endmodule

// File: tb/kbd_tx_engine_tb.sv
module kbd_tx_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD_N     = 8;
  localparam int TMO_N      = 400;
  localparam int SYNC_N     = 2;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_start = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       kbd_clk = 1'b1;
  logic       kbd_dat = 1'b1;
  logic       kclk_pull, kdat_pull, tx_busy, tx_done, tx_timeout;
  logic       kclk_line, kdat_line;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int busy_cyc = 0;

  // Open-drain wired-AND of keyboard and controller
  assign kclk_line = kbd_clk & ~kclk_pull;
  assign kdat_line = kbd_dat & ~kdat_pull;

  kbd_tx_engine #(
    .DATA_W(8), .HOLD_CYCLES(HOLD_N), .TIMEOUT_CYCLES(TMO_N), .SYNC_STAGES(SYNC_N)
  ) u_dut (
    .clk(clk), .rst(rst), .tx_start(tx_start), .tx_byte(tx_byte),
    .kclk_in(kclk_line), .kdat_in(kdat_line),
    .kclk_pull(kclk_pull), .kdat_pull(kdat_pull),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_timeout(tx_timeout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tx_done) done_cnt++;
    if (tx_busy) busy_cyc++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] frame_of(input logic [7:0] b);
    return {1'b1, ~(^b), b, 1'b0};
  endfunction

  // Host strobe, then measure the clock-hold window
  task automatic start_frame(input logic [7:0] b, output int hold_len,
                             output int dat_hi, output bit busy_now, output bit tmo_now);
    @(negedge clk);
    tx_byte = b; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    busy_now = tx_busy;
    tmo_now  = tx_timeout;
    hold_len = 0; dat_hi = 0;
    while (kclk_pull && hold_len < 10000) begin
      hold_len++;
      if (kdat_pull) dat_hi++;
      @(negedge clk);
    end
  endtask

  // Keyboard model: clocks eleven falls, samples the line, answers or not
  task automatic kbd_frame(input bit ack, input bit poke, input logic [7:0] pbyte,
                           output logic [10:0] seen, output bit lat_ok,
                           output bit hold_ok, output bit ack_ok);
    lat_ok = 1'b1; hold_ok = 1'b1; ack_ok = 1'b1;
    repeat (HALF) @(negedge clk);
    seen[0] = kdat_line;
    for (int k = 1; k <= 10; k++) begin
      logic prev_v, v;
      prev_v = kdat_line;
      kbd_clk = 1'b0;
      repeat (SYNC_N) @(negedge clk);
      if (kdat_line !== prev_v) lat_ok = 1'b0;
      @(negedge clk);
      v = kdat_line;
      for (int j = 0; j < HALF - SYNC_N - 1; j++) begin
        if (poke && k == 4 && j == 0) begin tx_byte = pbyte; tx_start = 1'b1; end
        else tx_start = 1'b0;
        @(negedge clk);
        if (kdat_line !== v) hold_ok = 1'b0;
      end
      tx_start = 1'b0;
      seen[k] = v;
      kbd_clk = 1'b1;
      repeat (HALF) begin
        @(negedge clk);
        if (kdat_line !== v) hold_ok = 1'b0;
      end
    end
    if (ack) kbd_dat = 1'b0;
    @(negedge clk);
    kbd_clk = 1'b0;
    repeat (SYNC_N) @(negedge clk);
    if (!tx_busy || tx_done) ack_ok = 1'b0;
    @(negedge clk);
    if (ack) begin
      if (tx_busy || !tx_done) ack_ok = 1'b0;
    end else if (!tx_busy || tx_done) ack_ok = 1'b0;
    repeat (HALF - SYNC_N - 1) @(negedge clk);
    kbd_clk = 1'b1; kbd_dat = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (tx_busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog expired: actual cycles=%0d expected < %0d", WATCHDOG, WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hl, dh, d0, pulls;
    bit bn, tn, lo, ho, ao;
    logic [10:0] seen, exp_f;

    // R1: reset state
    repeat (4) @(negedge clk);
    check({tx_busy, tx_done, tx_timeout, kclk_pull, kdat_pull} == 5'b0, "R1",
          "outputs in reset", {tx_busy, tx_done, tx_timeout, kclk_pull, kdat_pull}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({tx_busy, tx_done, tx_timeout, kclk_pull, kdat_pull} == 5'b0, "R1",
          "outputs after reset", {tx_busy, tx_done, tx_timeout, kclk_pull, kdat_pull}, 0);

    // R2..R5: one byte with full checking
    d0 = done_cnt;
    start_frame(8'h3C, hl, dh, bn, tn);
    check(bn == 1'b1, "R2", "busy after strobe", bn, 1);
    check(hl == HOLD_N + 1, "R2", "clock hold cycles", hl, HOLD_N + 1);
    check(dh == 1, "R2", "start bit cycles inside hold", dh, 1);
    check(kdat_pull == 1'b1, "R2", "start bit after clock release", kdat_pull, 1);
    kbd_frame(1'b1, 1'b0, 8'h00, seen, lo, ho, ao);
    exp_f = frame_of(8'h3C);
    check(seen == exp_f, "R3", "frame 3C", seen, exp_f);
    check(lo && ho, "R3", "bit latency and hold", {lo, ho}, 3);
    check(($countones(seen[9:1]) % 2) == 1, "R4", "odd ones data+parity",
          $countones(seen[9:1]), 1);
    check(ao, "R5", "ack timing", ao, 1);
    check(done_cnt == d0 + 1, "R5", "done pulses", done_cnt - d0, 1);

    // R6: strobe during transfer is ignored
    d0 = done_cnt;
    start_frame(8'h5A, hl, dh, bn, tn);
    kbd_frame(1'b1, 1'b1, 8'hFF, seen, lo, ho, ao);
    exp_f = frame_of(8'h5A);
    check(seen == exp_f, "R6", "frame unchanged by strobe", seen, exp_f);
    check(done_cnt == d0 + 1 && ao, "R6", "single done", done_cnt - d0, 1);
    pulls = 0;
    repeat (50) begin @(negedge clk); if (kclk_pull || tx_busy) pulls++; end
    check(pulls == 0, "R6", "no second frame", pulls, 0);

    // R7: silent keyboard
    d0 = done_cnt;
    busy_cyc = 0;
    start_frame(8'h81, hl, dh, bn, tn);
    wait_idle();
    check(busy_cyc == TMO_N, "R7", "busy cycles on timeout", busy_cyc, TMO_N);
    check(tx_timeout && !kclk_pull && !kdat_pull, "R7", "timeout flag and lines",
          {tx_timeout, kclk_pull, kdat_pull}, 3'b100);
    check(done_cnt == d0, "R7", "no done on timeout", done_cnt - d0, 0);

    // R8: sticky until the next accepted strobe
    repeat (20) @(negedge clk);
    check(tx_timeout == 1'b1, "R8", "timeout held while idle", tx_timeout, 1);
    busy_cyc = 0;
    d0 = done_cnt;
    start_frame(8'hC7, hl, dh, bn, tn);
    check(tn == 1'b0, "R8", "timeout cleared on accept", tn, 0);

    // R7: frame clocked but keyboard answers with data high
    kbd_frame(1'b0, 1'b0, 8'h00, seen, lo, ho, ao);
    exp_f = frame_of(8'hC7);
    check(seen == exp_f, "R3", "frame C7", seen, exp_f);
    check(ao, "R7", "high data fall not an ack", ao, 1);
    wait_idle();
    check(busy_cyc == TMO_N, "R7", "busy cycles without ack", busy_cyc, TMO_N);
    check(tx_timeout && done_cnt == d0, "R7", "timeout without ack",
          {tx_timeout, done_cnt - d0}, 2);

    // Sweep every byte value
    for (int b = 0; b < 256; b++) begin
      d0 = done_cnt;
      start_frame(b[7:0], hl, dh, bn, tn);
      check(hl == HOLD_N + 1 && dh == 1 && bn && !tn, "R2", "claim sweep", hl, HOLD_N + 1);
      kbd_frame(1'b1, 1'b0, 8'h00, seen, lo, ho, ao);
      exp_f = frame_of(b[7:0]);
      check(seen == exp_f, "R3", "frame sweep", seen, exp_f);
      check(lo && ho, "R3", "latency/hold sweep", {lo, ho}, 3);
      check(seen[9] == ~(^b[7:0]), "R4", "parity sweep", seen[9], ~(^b[7:0]));
      check(ao && done_cnt == d0 + 1, "R5", "ack sweep", done_cnt - d0, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule